// File: doc/BRIEF.md
# Multi-Channel ADC Threshold Monitor

The monitor sits beside an analog-to-digital converter and watches up to eight signals on a periodic schedule. Each channel has its own configuration window. The window names the converter input to sample, a 16-bit lower limit and a 16-bit upper limit, the shared interval timer that paces the channel, a calibration and settle sideband, and a set of enables. Three interval timers count an external `tick` input. When a timer expires, every enabled channel tied to it becomes pending. The pending channels are then converted one at a time, lowest index first.

A sequencer state machine handles each conversion. It has three states. `ST_IDLE` waits for a pending channel. `ST_REQ` holds `adc_req` together with the input select and sideband until the converter answers with `adc_valid`. `ST_CMP` compares the returned code with the channel's limits and updates the status. The transitions are: IDLE→REQ when any channel is pending (the lowest one is granted), REQ→REQ while no answer has arrived, REQ→CMP on `adc_valid`, and CMP→IDLE unconditionally.

A result below the lower limit sets the channel's bit in the low status register. A result above the upper limit sets its bit in the high status register. Software clears these bits by writing 1 to them. A level interrupt is raised while any measuring channel has a status bit whose interrupt enable is set. Software reaches the block through a byte-wide register bus. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `adc_thresh_mon`

## Requirements
- R1: After reset, register 0x0F reads 8 (the channel count), 0x0A and 0x0B read 0, 0x44 reads 3, 0x45 reads 0xA4, and `irq` and `adc_req` are 0.
- R2: Channel n owns bytes 0x60+8n..0x67+8n, in this order: input select, lower limit LSB, lower limit MSB, upper limit LSB, upper limit MSB, timer select (bits [1:0]), control (bits [5:0]), enables (bit 7 measure, bit 1 high interrupt, bit 0 low interrupt). Unimplemented bits read 0.
- R3: Timer 1 takes its code from 0x44, timer 2 from 0x45[7:4] and timer 3 from 0x45[3:0]. A timer expires every code+1 ticks, counted from the last write of 1 to bit 7 of 0x47 (restart). Timers run only while bit 7 of 0x46 (global enable) is 1 and a restart has occurred since the global enable was last cleared.
- R4: Timer select 0, 1 or 2 picks timer 1, 2 or 3. Select 3, or a cleared measure enable, means the channel is never converted. Each expiry of the chosen timer produces exactly one conversion of the channel.
- R5: `adc_req` stays high with `adc_sel` stable until `adc_valid` is seen, and only one request is outstanding at a time.
- R6: A returned code strictly below the lower limit sets bit n of 0x0A. A code strictly above the upper limit sets bit n of 0x0B. A code equal to a limit sets neither.
- R7: Writing 1 to a status bit clears it. Bits written with 0 are kept.
- R8: `irq` is the OR over channels of measure-enable AND ((low status AND low interrupt enable) OR (high status AND high interrupt enable)).
- R9: Channels that become due on the same tick are converted in ascending channel order.
- R10: During a request, `adc_settle` carries control bits [3:0] and `adc_cal` carries control bits [5:4] of the channel being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse counted by the interval timers |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| adc_req | output | 1 | Conversion request, held until answered |
| adc_sel | output | 8 | Converter input select of the served channel |
| adc_settle | output | 4 | Settle-delay index sideband |
| adc_cal | output | 2 | Calibration select sideband |
| adc_valid | input | 1 | Converter result strobe |
| adc_code | input | 16 | Converter result |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is several channels on different timers becoming due on the same tick while the converter answers with varying latency. That is where ordering, pending bookkeeping and the one-outstanding rule all interact. The stimulus programs small timer codes with different periods and random per-channel timer selects, enables and limits. It spaces ticks so that every round of conversions drains before the next tick, which makes the number of conversions per channel exactly predictable from the tick count. A directed restart sequence and an equal-limit channel cover the edges that random limits rarely hit.

// File: rtl/adcmon_pkg.sv
package adcmon_pkg;
    localparam int CODE_W = 16;

    localparam logic [7:0] A_STLO   = 8'h0A;
    localparam logic [7:0] A_STHI   = 8'h0B;
    localparam logic [7:0] A_NCH    = 8'h0F;
    localparam logic [7:0] A_TMR1   = 8'h44;
    localparam logic [7:0] A_TMR23  = 8'h45;
    localparam logic [7:0] A_GEN    = 8'h46;
    localparam logic [7:0] A_STRB   = 8'h47;
    localparam logic [7:0] WIN_BASE = 8'h60;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_CMP  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [7:0]        sel;
        logic [CODE_W-1:0] thr_lo;
        logic [CODE_W-1:0] thr_hi;
        logic [1:0]        tsel;
        logic [5:0]        ctl;
        logic              meas_en;
        logic              hi_ie;
        logic              lo_ie;
    } ch_cfg_t;
endpackage

// File: rtl/adcmon_regs.sv
module adcmon_regs
    import adcmon_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [7:0]             addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output ch_cfg_t                cfg [NCH],
    output logic [7:0]             t1_code,
    output logic [3:0]             t2_code,
    output logic [3:0]             t3_code,
    output logic                   glb_en,
    output logic                   restart,
    output logic [NCH-1:0]         st_lo,
    output logic [NCH-1:0]         st_hi,
    input  logic                   upd,
    input  logic [$clog2(NCH)-1:0] upd_idx,
    input  logic                   upd_lo,
    input  logic                   upd_hi
);
    localparam int CW = $clog2(NCH);

    logic           in_win;
    logic [7:0]     win_off;
    logic [CW-1:0]  win_ch;
    logic [NCH-1:0] clr_lo, clr_hi, set_lo, set_hi, one_hot;
    ch_cfg_t        rc;

    assign win_off = addr - WIN_BASE;
    assign win_ch  = win_off[3 +: CW];
    assign in_win  = (addr >= WIN_BASE) && (int'(addr) < int'(WIN_BASE) + 8 * NCH);
    assign restart = we && (addr == A_STRB) && wdata[7];

    // per-channel configuration windows
    for (genvar g = 0; g < NCH; g++) begin : g_win
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[g] <= '0;
            end else if (we && in_win && (win_ch == CW'(g))) begin
                case (addr[2:0])
                    3'd0: cfg[g].sel          <= wdata;
                    3'd1: cfg[g].thr_lo[7:0]  <= wdata;
                    3'd2: cfg[g].thr_lo[15:8] <= wdata;
                    3'd3: cfg[g].thr_hi[7:0]  <= wdata;
                    3'd4: cfg[g].thr_hi[15:8] <= wdata;
                    3'd5: cfg[g].tsel         <= wdata[1:0];
                    3'd6: cfg[g].ctl          <= wdata[5:0];
                    default: begin
                        cfg[g].meas_en <= wdata[7];
                        cfg[g].hi_ie   <= wdata[1];
                        cfg[g].lo_ie   <= wdata[0];
                    end
                endcase
            end
        end
    end

    // global registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t1_code <= 8'd3;
            t2_code <= 4'd10;
            t3_code <= 4'd4;
            glb_en  <= 1'b0;
        end else if (we) begin
            if (addr == A_TMR1)  t1_code <= wdata;
            if (addr == A_TMR23) {t2_code, t3_code} <= wdata;
            if (addr == A_GEN)   glb_en <= wdata[7];
        end
    end

    // status: write-one-to-clear, a new result wins over a clear
    assign one_hot = {{(NCH-1){1'b0}}, 1'b1} << upd_idx;
    assign clr_lo  = (we && addr == A_STLO) ? wdata[NCH-1:0] : '0;
    assign clr_hi  = (we && addr == A_STHI) ? wdata[NCH-1:0] : '0;
    assign set_lo  = (upd && upd_lo) ? one_hot : '0;
    assign set_hi  = (upd && upd_hi) ? one_hot : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_lo <= '0;
            st_hi <= '0;
        end else begin
            st_lo <= (st_lo & ~clr_lo) | set_lo;
            st_hi <= (st_hi & ~clr_hi) | set_hi;
        end
    end

    // read mux
    always_comb begin
        rc    = cfg[win_ch];
        rdata = 8'h00;
        if (in_win) begin
            case (addr[2:0])
                3'd0: rdata = rc.sel;
                3'd1: rdata = rc.thr_lo[7:0];
                3'd2: rdata = rc.thr_lo[15:8];
                3'd3: rdata = rc.thr_hi[7:0];
                3'd4: rdata = rc.thr_hi[15:8];
                3'd5: rdata = {6'd0, rc.tsel};
                3'd6: rdata = {2'd0, rc.ctl};
                default: rdata = {rc.meas_en, 5'd0, rc.hi_ie, rc.lo_ie};
            endcase
        end else begin
            case (addr)
                A_STLO:  rdata = 8'(st_lo);
                A_STHI:  rdata = 8'(st_hi);
                A_NCH:   rdata = 8'(NCH);
                A_TMR1:  rdata = t1_code;
                A_TMR23: rdata = {t2_code, t3_code};
                A_GEN:   rdata = {glb_en, 7'd0};
                default: rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/adcmon_timers.sv
module adcmon_timers #(
    parameter int NT = 3,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          glb_en,
    input  logic          restart,
    input  logic          tick,
    input  logic [TW-1:0] code [NT],
    output logic [NT-1:0] due
);
    logic started;
    logic run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       started <= 1'b0;
        else if (!glb_en) started <= 1'b0;
        else if (restart) started <= 1'b1;
    end

    assign run = started && glb_en;

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        logic [TW-1:0] cnt;
        logic          hit;

        assign hit    = (cnt == code[g]);
        assign due[g] = run && tick && !restart && hit;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt <= '0;
            else if (restart || !run)  cnt <= '0;
            else if (tick)             cnt <= hit ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adcmon_seq.sv
module adcmon_seq
    import adcmon_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   glb_en,
    input  logic [NCH-1:0]         due_ch,
    input  logic                   adc_valid,
    input  logic [CODE_W-1:0]      adc_code,
    input  logic [CODE_W-1:0]      lo_thr,
    input  logic [CODE_W-1:0]      hi_thr,
    output logic                   adc_req,
    output logic [$clog2(NCH)-1:0] srv_idx,
    output logic                   upd,
    output logic                   upd_lo,
    output logic                   upd_hi
);
    localparam int IW = $clog2(NCH);

    seq_state_t        state, state_n;
    logic [NCH-1:0]    pend, gnt_mask;
    logic [IW-1:0]     pick;
    logic              grant;
    logic [CODE_W-1:0] code_q;

    // lowest pending index wins
    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) pick = IW'(i);
        end
    end

    assign grant    = (state == ST_IDLE) && (|pend);
    assign gnt_mask = grant ? ({{(NCH-1){1'b0}}, 1'b1} << pick) : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (|pend)     state_n = ST_REQ;
            ST_REQ:  if (adc_valid) state_n = ST_CMP;
            ST_CMP:                 state_n = ST_IDLE;
            default:                state_n = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= '0;
            srv_idx <= '0;
            code_q  <= '0;
        end else begin
            pend <= glb_en ? ((pend & ~gnt_mask) | due_ch) : '0;
            if (grant) srv_idx <= pick;
            if (state == ST_REQ && adc_valid) code_q <= adc_code;
        end
    end

    // outputs
    always_comb begin
        adc_req = (state == ST_REQ);
        upd     = (state == ST_CMP);
        upd_lo  = upd && (code_q < lo_thr);
        upd_hi  = upd && (code_q > hi_thr);
    end
endmodule

// File: rtl/adc_thresh_mon.sv
module adc_thresh_mon
    import adcmon_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              adc_req,
    output logic [7:0]        adc_sel,
    output logic [3:0]        adc_settle,
    output logic [1:0]        adc_cal,
    input  logic              adc_valid,
    input  logic [CODE_W-1:0] adc_code,
    output logic              irq
);
    localparam int IW = $clog2(NCH);
    localparam int NT = 3;

    ch_cfg_t        cfg [NCH];
    ch_cfg_t        srv_cfg;
    logic [7:0]     t1_code;
    logic [3:0]     t2_code, t3_code;
    logic [7:0]     tcode [NT];
    logic           glb_en, restart;
    logic [NCH-1:0] st_lo, st_hi, due_ch, meas_v, lie_v, hie_v;
    logic [NT-1:0]  due_t;
    logic [3:0]     due_sel;
    logic [IW-1:0]  srv_idx;
    logic           upd, upd_lo, upd_hi;
    logic [1:0]     srv_tsel;
    logic           srv_meas;

    adcmon_regs #(.NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .cfg(cfg), .t1_code(t1_code), .t2_code(t2_code),
        .t3_code(t3_code), .glb_en(glb_en), .restart(restart),
        .st_lo(st_lo), .st_hi(st_hi), .upd(upd), .upd_idx(srv_idx),
        .upd_lo(upd_lo), .upd_hi(upd_hi)
    );

    assign tcode[0] = t1_code;
    assign tcode[1] = {4'd0, t2_code};
    assign tcode[2] = {4'd0, t3_code};

    adcmon_timers #(.NT(NT), .TW(8)) u_tmr (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .restart(restart),
        .tick(tick), .code(tcode), .due(due_t)
    );

    assign due_sel = {1'b0, due_t};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign due_ch[g] = cfg[g].meas_en && due_sel[cfg[g].tsel];
        assign meas_v[g] = cfg[g].meas_en;
        assign lie_v[g]  = cfg[g].lo_ie;
        assign hie_v[g]  = cfg[g].hi_ie;
    end

    assign srv_cfg  = cfg[srv_idx];
    assign srv_tsel = srv_cfg.tsel;
    assign srv_meas = srv_cfg.meas_en;

    adcmon_seq #(.NCH(NCH)) u_seq (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .due_ch(due_ch),
        .adc_valid(adc_valid), .adc_code(adc_code),
        .lo_thr(srv_cfg.thr_lo), .hi_thr(srv_cfg.thr_hi),
        .adc_req(adc_req), .srv_idx(srv_idx), .upd(upd),
        .upd_lo(upd_lo), .upd_hi(upd_hi)
    );

    assign adc_sel    = srv_cfg.sel;
    assign adc_settle = srv_cfg.ctl[3:0];
    assign adc_cal    = srv_cfg.ctl[5:4];
    assign irq        = |(meas_v & ((st_lo & lie_v) | (st_hi & hie_v)));
endmodule

// File: rtl/adcmon_checker.sv
module adcmon_checker #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           adc_req,
    input logic           adc_valid,
    input logic [7:0]     adc_sel,
    input logic           bus_we,
    input logic [7:0]     bus_addr,
    input logic [NCH-1:0] st_lo,
    input logic [NCH-1:0] st_hi,
    input logic           irq,
    input logic [1:0]     srv_tsel,
    input logic           srv_meas
);
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_valid) |=> (adc_req && $stable(adc_sel)));

    a_r5_valid_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid |-> adc_req);

    a_r4_no_unscheduled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_req) |-> (srv_meas && srv_tsel != 2'd3));

    a_r7_low_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 8'h0A) |=> ((st_lo & $past(st_lo)) == $past(st_lo)));

    a_r7_high_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == 8'h0B) |=> ((st_hi & $past(st_hi)) == $past(st_hi)));

    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((st_lo | st_hi) != '0));
endmodule

bind adc_thresh_mon adcmon_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_req(adc_req), .adc_valid(adc_valid),
    .adc_sel(adc_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .st_lo(st_lo), .st_hi(st_hi), .irq(irq),
    .srv_tsel(srv_tsel), .srv_meas(srv_meas)
);

// File: tb/test_adc_thresh_mon.sv
module test_adc_thresh_mon;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        adc_req;
    logic [7:0]  adc_sel;
    logic [3:0]  adc_settle;
    logic [1:0]  adc_cal;
    logic        adc_valid = 1'b0;
    logic [15:0] adc_code = 16'h0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int req_cnt [8];
    int last_ch = -1;

    logic [7:0]  b_sel  [8];
    logic [15:0] b_lo   [8];
    logic [15:0] b_hi   [8];
    logic [1:0]  b_tsel [8];
    logic [5:0]  b_ctl  [8];
    logic        b_meas [8];
    logic        b_hie  [8];
    logic        b_lie  [8];

    always #10 clk = ~clk;

    adc_thresh_mon i_adc_thresh_mon (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .adc_req(adc_req), .adc_sel(adc_sel), .adc_settle(adc_settle),
        .adc_cal(adc_cal), .adc_valid(adc_valid), .adc_code(adc_code), .irq(irq)
    );

    function automatic logic [15:0] code_of(input logic [7:0] s);
        return {s ^ 8'h5A, ~s};
    endfunction

    function automatic int period_of(input logic [1:0] ts);
        return (ts == 2'd0) ? 2 : (ts == 2'd1) ? 3 : 4;
    endfunction

    function automatic int exp_count(input int ch, input int nticks);
        if (!b_meas[ch] || b_tsel[ch] == 2'd3) return 0;
        return nticks / period_of(b_tsel[ch]);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr_ch(input int ch);
        logic [7:0] base;
        base = 8'(8'h60 + 8 * ch);
        wr(base + 8'd0, b_sel[ch]);
        wr(base + 8'd1, b_lo[ch][7:0]);
        wr(base + 8'd2, b_lo[ch][15:8]);
        wr(base + 8'd3, b_hi[ch][7:0]);
        wr(base + 8'd4, b_hi[ch][15:8]);
        wr(base + 8'd5, {6'd0, b_tsel[ch]});
        wr(base + 8'd6, {2'd0, b_ctl[ch]});
        wr(base + 8'd7, {b_meas[ch], 5'd0, b_hie[ch], b_lie[ch]});
    endtask

    task automatic do_tick;
        @(negedge clk);
        last_ch = -1;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (100) @(negedge clk);
    endtask

    task automatic clear_counts;
        for (int i = 0; i < 8; i++) req_cnt[i] = 0;
    endtask

    // converter responder with ordering and sideband checks
    initial begin
        forever begin
            @(negedge clk);
            if (adc_req) begin
                automatic int ch = int'(adc_sel[7:4]);
                automatic int lat = $urandom_range(0, 3);
                if (ch < 8) begin
                    req_cnt[ch]++;
                    chk("R9 ascending order", 32'(ch > last_ch), 32'd1);
                    chk("R10 settle sideband", 32'(adc_settle), 32'(b_ctl[ch][3:0]));
                    chk("R10 cal sideband", 32'(adc_cal), 32'(b_ctl[ch][5:4]));
                    last_ch = ch;
                end
                repeat (lat) @(negedge clk);
                adc_code = code_of(adc_sel);
                adc_valid = 1'b1;
                @(negedge clk);
                adc_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] exp_lo, exp_hi;
        logic       exp_irq;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h0F, d); chk("R1 channel count", 32'(d), 32'd8);
        rd(8'h0A, d); chk("R1 low status reset", 32'(d), 32'd0);
        rd(8'h0B, d); chk("R1 high status reset", 32'(d), 32'd0);
        rd(8'h44, d); chk("R1 timer1 default", 32'(d), 32'h03);
        rd(8'h45, d); chk("R1 timer2/3 default", 32'(d), 32'hA4);
        chk("R1 irq reset", 32'(irq), 32'd0);
        chk("R1 req reset", 32'(adc_req), 32'd0);

        // R2 window layout and readback masks
        for (int k = 0; k < 8; k++) wr(8'h78 + 8'(k), 8'hFF);
        rd(8'h78, d); chk("R2 select", 32'(d), 32'hFF);
        rd(8'h7A, d); chk("R2 lower MSB", 32'(d), 32'hFF);
        rd(8'h7D, d); chk("R2 timer select mask", 32'(d), 32'h03);
        rd(8'h7E, d); chk("R2 control mask", 32'(d), 32'h3F);
        rd(8'h7F, d); chk("R2 enable mask", 32'(d), 32'h83);
        wr(8'h7F, 8'h00);

        // short timer periods: 2, 3, 4 ticks
        wr(8'h44, 8'h01);
        wr(8'h45, 8'h23);

        // R3 directed restart: all channels on timer 1
        for (int i = 0; i < 8; i++) begin
            b_sel[i] = 8'(i * 16); b_lo[i] = 16'h0; b_hi[i] = 16'hFFFF;
            b_tsel[i] = 2'd0; b_ctl[i] = 6'(i * 5); b_meas[i] = 1'b1;
            b_hie[i] = 1'b0; b_lie[i] = 1'b0;
            wr_ch(i);
        end
        clear_counts();
        wr(8'h46, 8'h80);
        wr(8'h47, 8'h80);
        do_tick();
        wr(8'h47, 8'h80);
        do_tick();
        chk("R3 restart clears count", 32'(req_cnt[0]), 32'd0);
        do_tick();
        chk("R3 period after restart", 32'(req_cnt[0]), 32'd1);
        chk("R3 period after restart ch7", 32'(req_cnt[7]), 32'd1);

        // R3 global enable off stops scheduling
        wr(8'h46, 8'h00);
        clear_counts();
        do_tick(); do_tick(); do_tick();
        chk("R3 disabled no requests", 32'(req_cnt[0] + req_cnt[5]), 32'd0);

        // random rounds
        for (int r = 0; r < 4; r++) begin
            wr(8'h46, 8'h00);
            for (int i = 0; i < 8; i++) begin
                b_sel[i]  = 8'(i * 16 + r);
                b_lo[i]   = 16'($urandom);
                b_hi[i]   = 16'($urandom);
                b_tsel[i] = 2'($urandom_range(0, 3));
                b_ctl[i]  = 6'($urandom);
                b_meas[i] = ($urandom_range(0, 5) != 0);
                b_hie[i]  = 1'($urandom);
                b_lie[i]  = 1'($urandom);
            end
            if (r == 0) begin
                // R6 equality on both limits
                b_lo[0] = code_of(b_sel[0]); b_hi[0] = code_of(b_sel[0]);
                b_meas[0] = 1'b1; b_tsel[0] = 2'd0;
            end
            for (int i = 0; i < 8; i++) wr_ch(i);
            wr(8'h0A, 8'hFF);
            wr(8'h0B, 8'hFF);
            clear_counts();
            wr(8'h46, 8'h80);
            wr(8'h47, 8'h80);
            for (int t = 0; t < 12; t++) do_tick();

            exp_lo = 8'h00; exp_hi = 8'h00; exp_irq = 1'b0;
            for (int i = 0; i < 8; i++) begin
                automatic int ec = exp_count(i, 12);
                chk("R4 conversions per channel", 32'(req_cnt[i]), 32'(ec));
                if (ec > 0 && code_of(b_sel[i]) < b_lo[i]) exp_lo[i] = 1'b1;
                if (ec > 0 && code_of(b_sel[i]) > b_hi[i]) exp_hi[i] = 1'b1;
                if (b_meas[i] && ((exp_lo[i] && b_lie[i]) || (exp_hi[i] && b_hie[i])))
                    exp_irq = 1'b1;
            end
            rd(8'h0A, d); chk("R6 low status", 32'(d), 32'(exp_lo));
            rd(8'h0B, d); chk("R6 high status", 32'(d), 32'(exp_hi));
            chk("R8 interrupt level", 32'(irq), 32'(exp_irq));

            // R7 clear only the lowest set low bit, with scheduling stopped
            wr(8'h46, 8'h00);
            begin
                automatic logic [7:0] m = exp_lo & (~exp_lo + 8'd1);
                wr(8'h0A, m);
                rd(8'h0A, d); chk("R7 write-one-to-clear", 32'(d), 32'(exp_lo & ~m));
            end
            wr(8'h0B, 8'hFF);
            rd(8'h0B, d); chk("R7 clear all high", 32'(d), 32'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule